// File: doc/BRIEF.md
# Security Session State Tracker

This block keeps the access privileges of one host session on a secure memory. It takes pass/fail results from the password-compare engine and the authentication engine. It also takes an encryption-activation request and a per-command MAC-check result. From these it keeps the session's communication mode, the password set in force and the key the session authenticated with. Each password set and each key has its own trial counter. Once a counter reaches its limit, every later attempt on that index counts as a failure.

The memory controller presents the access requirements of the zone it is about to touch: an optional password set, an optional key and an encryption flag. The block answers at once with read and write grants. Privileges build on each other: authentication comes before encryption. A failed re-authentication or a MAC mismatch revokes them. A write password also grants read access.

Top module: `sess_tracker`

## Requirements
- R1: After power-on reset (`rst_ni` low) the mode is standard (`mode_o` = 0), no password is active (`pw_active_o` = 0, `pw_write_o` = 0) and `key_o` = 0. The mode encoding is standard = 0, authenticated = 1, encrypted = 2. `key_o` reads 0 whenever the mode is standard.
- R2: A successful authentication result for key k enters authenticated mode with `key_o` = k on the next clock. This happens from any mode, so a session that was encrypted drops back to authenticated.
- R3: An encryption request moves the mode from authenticated to encrypted on the next clock. In standard mode the request is ignored, and in encrypted mode it has no effect.
- R4: Only one password is active at a time. A successful presentation of set s makes s the active set on the next clock, with the write flag taken from `pw_write_i`. It replaces any earlier password. A failed presentation leaves no password active.
- R5: With `zone_pw_en_i` high, `write_ok_o` requires the active set to equal `zone_pw_set_i` with the write flag set. `read_ok_o` accepts that set with either flag, so a write password also grants read.
- R6: A failed authentication result clears any earlier authentication and returns the mode to standard on the next clock.
- R7: A MAC mismatch (`mac_valid_i` high, `mac_ok_i` low) in authenticated or encrypted mode returns the mode to standard on the next clock. In standard mode a mismatch is ignored, and a matching MAC never changes the state.
- R8: With `zone_key_en_i` high, both grants require a mode other than standard and `key_o` equal to `zone_key_i`. With `zone_enc_i` high, both grants also require encrypted mode. The grants are combinational in the zone inputs and the current state.
- R9: Each password set and each key has a 3-bit trial counter. If the counter is below its limit input, a failure increments it and a success clears it. If the counter equals or exceeds the limit, the attempt counts as a failure and the counter holds. A limit of 0 therefore blocks every attempt.
- R10: `sess_rst_i` clears the mode, the active password and the key on the next clock, as power-on reset does. It leaves the trial counters unchanged, and attempts made in the same cycle still update the counters.
- R11: In one cycle, session reset takes precedence over a MAC mismatch. A MAC mismatch takes precedence over an authentication result, and an authentication result over an encryption request. A password result arriving with a session reset is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sess_rst_i | input | 1 | Session reset request, synchronous |
| pw_valid_i | input | 1 | Password compare result strobe |
| pw_pass_i | input | 1 | Password compare matched |
| pw_write_i | input | 1 | Presented password was the write password |
| pw_set_i | input | 3 | Password set of the attempt |
| pw_limit_i | input | 3 | Password trial limit |
| auth_valid_i | input | 1 | Authentication result strobe |
| auth_pass_i | input | 1 | Authentication succeeded |
| auth_key_i | input | 2 | Key of the authentication attempt |
| auth_limit_i | input | 3 | Authentication trial limit |
| enc_req_i | input | 1 | Encryption activation request |
| mac_valid_i | input | 1 | MAC check result strobe |
| mac_ok_i | input | 1 | MAC matched |
| zone_pw_en_i | input | 1 | Zone needs a password |
| zone_pw_set_i | input | 3 | Password set the zone needs |
| zone_key_en_i | input | 1 | Zone needs authentication |
| zone_key_i | input | 2 | Key the zone needs |
| zone_enc_i | input | 1 | Zone needs encrypted mode |
| mode_o | output | 2 | Session mode: 0 standard, 1 authenticated, 2 encrypted |
| pw_active_o | output | 1 | A password is active |
| pw_set_o | output | 3 | Active password set |
| pw_write_o | output | 1 | Active password is a write password |
| key_o | output | 2 | Authenticated key |
| read_ok_o | output | 1 | Read granted for the presented zone |
| write_ok_o | output | 1 | Write granted for the presented zone |

## Verification
Every event input acts through one register stage. A strobe driven during cycle n shows on `mode_o`, `key_o` and the password outputs after the rising edge that ends cycle n. The grants are combinational and follow the zone inputs within the same cycle. The bench drives the inputs just after a falling edge and checks the grants about 1 ns later, against the model state that stands before the edge. It then lets the rising edge pass, advances its model with the same inputs, and checks the registered outputs at the following falling edge. The trial-limit, priority and reset-versus-counter cases are run as directed sequences, and a long random phase follows them.

// File: rtl/sess_pkg.sv
package sess_pkg;
  localparam int unsigned N_PW   = 8;
  localparam int unsigned N_KEY  = 4;
  localparam int unsigned CNT_W  = 3;
  localparam int unsigned PW_W   = $clog2(N_PW);
  localparam int unsigned KEY_W  = $clog2(N_KEY);

  typedef enum logic [1:0] {
    MODE_STD  = 2'd0,
    MODE_AUTH = 2'd1,
    MODE_ENC  = 2'd2
  } mode_e;
endpackage

// File: rtl/sess_trial_ctr.sv
module sess_trial_ctr #(
  parameter int unsigned N_IDX = 8,
  parameter int unsigned CNT_W = 3,
  localparam int unsigned IDX_W = (N_IDX > 1) ? $clog2(N_IDX) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             pass_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             ok_o,
  output logic             bad_o
);
  logic [CNT_W-1:0] cnt_q [N_IDX];
  logic [N_IDX-1:0] sel;
  logic             locked;

  always_comb begin
    for (int i = 0; i < N_IDX; i++) sel[i] = (idx_i == IDX_W'(i));
  end

  assign locked = (cnt_q[idx_i] >= limit_i);
  assign ok_o   = valid_i && pass_i && !locked;
  assign bad_o  = valid_i && !(pass_i && !locked);

  for (genvar g = 0; g < N_IDX; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[g] <= '0;
      end else if (valid_i && sel[g] && !locked) begin
        cnt_q[g] <= pass_i ? '0 : cnt_q[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sess_state.sv
module sess_state
  import sess_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sess_rst_i,
  input  logic             pw_ok_i,
  input  logic             pw_bad_i,
  input  logic             pw_write_i,
  input  logic [PW_W-1:0]  pw_set_i,
  input  logic             auth_ok_i,
  input  logic             auth_bad_i,
  input  logic [KEY_W-1:0] auth_key_i,
  input  logic             enc_req_i,
  input  logic             mac_valid_i,
  input  logic             mac_ok_i,
  output mode_e            mode_o,
  output logic [KEY_W-1:0] key_o,
  output logic             pw_active_o,
  output logic             pw_write_o,
  output logic [PW_W-1:0]  pw_set_o
);
  mode_e            mode_q;
  logic [KEY_W-1:0] key_q;
  logic             mac_bad;

  assign mac_bad = mac_valid_i && !mac_ok_i && (mode_q != MODE_STD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (sess_rst_i || mac_bad) begin
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (auth_ok_i) begin
      mode_q <= MODE_AUTH;
      key_q  <= auth_key_i;
    end else if (auth_bad_i) begin
      mode_q <= MODE_STD;
      key_q  <= '0;
    end else if (enc_req_i && mode_q == MODE_AUTH) begin
      mode_q <= MODE_ENC;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_active_o <= 1'b0;
      pw_write_o  <= 1'b0;
      pw_set_o    <= '0;
    end else if (sess_rst_i || pw_bad_i) begin
      pw_active_o <= 1'b0;
      pw_write_o  <= 1'b0;
      pw_set_o    <= '0;
    end else if (pw_ok_i) begin
      pw_active_o <= 1'b1;
      pw_write_o  <= pw_write_i;
      pw_set_o    <= pw_set_i;
    end
  end

  assign mode_o = mode_q;
  assign key_o  = key_q;
endmodule

// File: rtl/sess_zone_gate.sv
module sess_zone_gate
  import sess_pkg::*;
(
  input  mode_e            mode_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             pw_active_i,
  input  logic             pw_write_i,
  input  logic [PW_W-1:0]  pw_set_i,
  input  logic             zone_pw_en_i,
  input  logic [PW_W-1:0]  zone_pw_set_i,
  input  logic             zone_key_en_i,
  input  logic [KEY_W-1:0] zone_key_i,
  input  logic             zone_enc_i,
  output logic             read_ok_o,
  output logic             write_ok_o
);
  logic pw_match, key_ok, enc_ok;

  assign pw_match = pw_active_i && (pw_set_i == zone_pw_set_i);
  assign key_ok   = !zone_key_en_i || ((mode_i != MODE_STD) && (key_i == zone_key_i));
  assign enc_ok   = !zone_enc_i || (mode_i == MODE_ENC);

  assign read_ok_o  = (!zone_pw_en_i || pw_match) && key_ok && enc_ok;
  assign write_ok_o = (!zone_pw_en_i || (pw_match && pw_write_i)) && key_ok && enc_ok;
endmodule

// File: rtl/sess_tracker.sv
module sess_tracker
  import sess_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sess_rst_i,
  input  logic             pw_valid_i,
  input  logic             pw_pass_i,
  input  logic             pw_write_i,
  input  logic [PW_W-1:0]  pw_set_i,
  input  logic [CNT_W-1:0] pw_limit_i,
  input  logic             auth_valid_i,
  input  logic             auth_pass_i,
  input  logic [KEY_W-1:0] auth_key_i,
  input  logic [CNT_W-1:0] auth_limit_i,
  input  logic             enc_req_i,
  input  logic             mac_valid_i,
  input  logic             mac_ok_i,
  input  logic             zone_pw_en_i,
  input  logic [PW_W-1:0]  zone_pw_set_i,
  input  logic             zone_key_en_i,
  input  logic [KEY_W-1:0] zone_key_i,
  input  logic             zone_enc_i,
  output logic [1:0]       mode_o,
  output logic             pw_active_o,
  output logic [PW_W-1:0]  pw_set_o,
  output logic             pw_write_o,
  output logic [KEY_W-1:0] key_o,
  output logic             read_ok_o,
  output logic             write_ok_o
);
  logic  pw_ok, pw_bad, auth_ok, auth_bad;
  mode_e mode;

  sess_trial_ctr #(.N_IDX(N_PW), .CNT_W(CNT_W)) u_pw_ctr (
    .clk_i, .rst_ni,
    .valid_i (pw_valid_i),
    .pass_i  (pw_pass_i),
    .idx_i   (pw_set_i),
    .limit_i (pw_limit_i),
    .ok_o    (pw_ok),
    .bad_o   (pw_bad)
  );

  sess_trial_ctr #(.N_IDX(N_KEY), .CNT_W(CNT_W)) u_auth_ctr (
    .clk_i, .rst_ni,
    .valid_i (auth_valid_i),
    .pass_i  (auth_pass_i),
    .idx_i   (auth_key_i),
    .limit_i (auth_limit_i),
    .ok_o    (auth_ok),
    .bad_o   (auth_bad)
  );

  sess_state u_state (
    .clk_i, .rst_ni,
    .sess_rst_i  (sess_rst_i),
    .pw_ok_i     (pw_ok),
    .pw_bad_i    (pw_bad),
    .pw_write_i  (pw_write_i),
    .pw_set_i    (pw_set_i),
    .auth_ok_i   (auth_ok),
    .auth_bad_i  (auth_bad),
    .auth_key_i  (auth_key_i),
    .enc_req_i   (enc_req_i),
    .mac_valid_i (mac_valid_i),
    .mac_ok_i    (mac_ok_i),
    .mode_o      (mode),
    .key_o       (key_o),
    .pw_active_o (pw_active_o),
    .pw_write_o  (pw_write_o),
    .pw_set_o    (pw_set_o)
  );

  sess_zone_gate u_gate (
    .mode_i        (mode),
    .key_i         (key_o),
    .pw_active_i   (pw_active_o),
    .pw_write_i    (pw_write_o),
    .pw_set_i      (pw_set_o),
    .zone_pw_en_i  (zone_pw_en_i),
    .zone_pw_set_i (zone_pw_set_i),
    .zone_key_en_i (zone_key_en_i),
    .zone_key_i    (zone_key_i),
    .zone_enc_i    (zone_enc_i),
    .read_ok_o     (read_ok_o),
    .write_ok_o    (write_ok_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/sess_tracker_chk.sv
module sess_tracker_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sess_rst_i,
  input logic       auth_valid_i,
  input logic       auth_pass_i,
  input logic       enc_req_i,
  input logic       mac_valid_i,
  input logic       mac_ok_i,
  input logic [1:0] mode_o,
  input logic       pw_active_o,
  input logic [1:0] key_o,
  input logic       read_ok_o,
  input logic       write_ok_o
);
  // R5
  p_write_implies_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_ok_o |-> read_ok_o);

  // R3
  p_enc_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> ($past(mode_o) == 2'd1 && $past(enc_req_i)));

  // R7
  p_mac_revoke_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && mac_valid_i && !mac_ok_i) |=> mode_o == 2'd0);

  // R6
  p_auth_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auth_valid_i && !auth_pass_i) |=> mode_o == 2'd0);

  // R10
  p_sess_rst_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_rst_i |=> (mode_o == 2'd0 && !pw_active_o));

  // R1
  p_std_key_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd0 |-> key_o == 2'd0);

  p_mode_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'd3);
endmodule

bind sess_tracker sess_tracker_chk u_chk (
  .clk_i, .rst_ni, .sess_rst_i, .auth_valid_i, .auth_pass_i, .enc_req_i,
  .mac_valid_i, .mac_ok_i, .mode_o, .pw_active_o, .key_o, .read_ok_o, .write_ok_o
);

// File: tb/sess_tracker_tb.sv
module sess_tracker_tb;
  logic clk = 0, rst_n = 0;
  logic sess_rst = 0, pw_valid = 0, pw_pass = 0, pw_write = 0;
  logic [2:0] pw_set = 0, pw_limit = 3'd7, auth_limit = 3'd7;
  logic auth_valid = 0, auth_pass = 0;
  logic [1:0] auth_key = 0;
  logic enc_req = 0, mac_valid = 0, mac_ok = 0;
  logic zpw_en = 0, zkey_en = 0, zenc = 0;
  logic [2:0] zpw_set = 0;
  logic [1:0] zkey = 0;
  logic [1:0] mode;
  logic pw_active, pw_wr_o, rd_ok, wr_ok;
  logic [2:0] pw_set_o;
  logic [1:0] key;

  int checks = 0, failures = 0;
  // reference model state
  int m_mode = 0, m_key = 0, m_pw_set = 0;
  bit m_pw_act = 0, m_pw_wr = 0;
  int pcnt[8];
  int acnt[4];

  always #4 clk = ~clk;

  sess_tracker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sess_rst_i(sess_rst),
    .pw_valid_i(pw_valid), .pw_pass_i(pw_pass), .pw_write_i(pw_write),
    .pw_set_i(pw_set), .pw_limit_i(pw_limit),
    .auth_valid_i(auth_valid), .auth_pass_i(auth_pass), .auth_key_i(auth_key),
    .auth_limit_i(auth_limit), .enc_req_i(enc_req),
    .mac_valid_i(mac_valid), .mac_ok_i(mac_ok),
    .zone_pw_en_i(zpw_en), .zone_pw_set_i(zpw_set), .zone_key_en_i(zkey_en),
    .zone_key_i(zkey), .zone_enc_i(zenc),
    .mode_o(mode), .pw_active_o(pw_active), .pw_set_o(pw_set_o),
    .pw_write_o(pw_wr_o), .key_o(key), .read_ok_o(rd_ok), .write_ok_o(wr_ok)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_read();
    bit pw_ok = !zpw_en || (m_pw_act && m_pw_set == zpw_set);
    bit k_ok  = !zkey_en || (m_mode != 0 && m_key == zkey);
    bit e_ok  = !zenc || m_mode == 2;
    return pw_ok && k_ok && e_ok;
  endfunction

  function automatic bit m_write();
    bit pw_ok = !zpw_en || (m_pw_act && m_pw_wr && m_pw_set == zpw_set);
    bit k_ok  = !zkey_en || (m_mode != 0 && m_key == zkey);
    bit e_ok  = !zenc || m_mode == 2;
    return pw_ok && k_ok && e_ok;
  endfunction

  task automatic m_update();
    bit p_ok = 0, p_bad = 0, a_ok = 0, a_bad = 0;
    if (pw_valid) begin
      if (pcnt[pw_set] >= pw_limit) p_bad = 1;
      else if (pw_pass) begin p_ok = 1; pcnt[pw_set] = 0; end
      else begin p_bad = 1; pcnt[pw_set]++; end
    end
    if (auth_valid) begin
      if (acnt[auth_key] >= auth_limit) a_bad = 1;
      else if (auth_pass) begin a_ok = 1; acnt[auth_key] = 0; end
      else begin a_bad = 1; acnt[auth_key]++; end
    end
    if (sess_rst || (mac_valid && !mac_ok && m_mode != 0)) begin m_mode = 0; m_key = 0; end
    else if (a_ok) begin m_mode = 1; m_key = auth_key; end
    else if (a_bad) begin m_mode = 0; m_key = 0; end
    else if (enc_req && m_mode == 1) m_mode = 2;
    if (sess_rst || p_bad) begin m_pw_act = 0; m_pw_wr = 0; m_pw_set = 0; end
    else if (p_ok) begin m_pw_act = 1; m_pw_wr = pw_write; m_pw_set = pw_set; end
  endtask

  task automatic cmp_all();
    chk("R2 mode", mode, m_mode);
    chk("R2 key", key, m_key);
    chk("R4 pw_active", pw_active, m_pw_act);
    chk("R4 pw_set", pw_set_o, m_pw_set);
    chk("R4 pw_write", pw_wr_o, m_pw_wr);
    chk("R8 read_ok", rd_ok, m_read());
    chk("R8 write_ok", wr_ok, m_write());
  endtask

  // inputs already driven after a negedge: check comb, clock, update model, check regs
  task automatic step();
    #1 cmp_all();
    @(posedge clk);
    m_update();
    @(negedge clk);
    cmp_all();
    sess_rst = 0; pw_valid = 0; auth_valid = 0; enc_req = 0; mac_valid = 0;
  endtask

  task automatic do_auth(input int k, input bit ok);
    auth_valid = 1; auth_pass = ok; auth_key = 2'(k); step();
  endtask

  task automatic do_pw(input int s, input bit ok, input bit wr);
    pw_valid = 1; pw_pass = ok; pw_set = 3'(s); pw_write = wr; step();
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    foreach (pcnt[i]) pcnt[i] = 0;
    foreach (acnt[i]) acnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset mode", mode, 0);
    chk("R1 reset pw_active", pw_active, 0);
    chk("R1 reset key", key, 0);
    rst_n = 1;
    @(negedge clk);

    // R3: encryption ignored in standard
    enc_req = 1; step();
    chk("R3 enc ignored in std", mode, 0);
    // R2
    do_auth(2, 1);
    chk("R2 auth enters mode 1", mode, 1);
    chk("R2 key 2", key, 2);
    enc_req = 1; step();
    chk("R3 enc from auth", mode, 2);
    // R8 zone key/enc
    zkey_en = 1; zkey = 2; zenc = 1; #1;
    chk("R8 read ok enc zone", rd_ok, 1);
    zkey = 1; #1;
    chk("R8 wrong key denied", rd_ok, 0);
    zkey = 2;
    // R7 ok MAC no effect, bad MAC revokes
    mac_valid = 1; mac_ok = 1; step();
    chk("R7 good mac keeps enc", mode, 2);
    mac_valid = 1; mac_ok = 0; step();
    chk("R7 bad mac to std", mode, 0);
    chk("R8 denied after revoke", rd_ok, 0);
    mac_valid = 1; mac_ok = 0; step();
    chk("R7 bad mac in std ignored", mode, 0);
    zkey_en = 0; zenc = 0;
    // R2 re-auth from encrypted drops to auth
    do_auth(1, 1); enc_req = 1; step();
    do_auth(3, 1);
    chk("R2 reauth from enc", mode, 1);
    // R6
    do_auth(3, 0);
    chk("R6 failed auth clears", mode, 0);
    // R4/R5
    zpw_en = 1; zpw_set = 5;
    do_pw(5, 1, 0);
    #1 chk("R5 read pw read", rd_ok, 1);
    chk("R5 read pw no write", wr_ok, 0);
    do_pw(5, 1, 1);
    #1 chk("R5 write pw grants read", rd_ok, 1);
    chk("R5 write pw grants write", wr_ok, 1);
    do_pw(2, 1, 1);
    chk("R4 replaced set", pw_set_o, 2);
    #1 chk("R4 old set no longer reads", rd_ok, 0);
    do_pw(2, 0, 1);
    chk("R4 failed pw clears", pw_active, 0);
    // R9 lockout: limit 2, two fails, then correct rejected
    pw_limit = 3'd2;
    do_pw(6, 0, 0);
    do_pw(6, 0, 0);
    do_pw(6, 1, 0);
    chk("R9 locked pw rejected", pw_active, 0);
    do_pw(4, 0, 0);
    do_pw(4, 1, 0);
    chk("R9 success below limit", pw_active, 1);
    do_pw(4, 0, 0);
    do_pw(4, 1, 0);
    chk("R9 counter cleared by success", pw_active, 1);
    auth_limit = 3'd0;
    do_auth(0, 1);
    chk("R9 limit 0 blocks auth", mode, 0);
    auth_limit = 3'd7;
    // R10: session reset clears, counters untouched
    do_auth(1, 1);
    do_pw(3, 1, 1);
    sess_rst = 1; step();
    chk("R10 rst mode", mode, 0);
    chk("R10 rst pw", pw_active, 0);
    do_pw(6, 1, 0);
    chk("R10 counters kept after rst", pw_active, 0);
    pw_limit = 3'd7;
    // R11 priorities
    do_auth(2, 1);
    mac_valid = 1; mac_ok = 0; auth_valid = 1; auth_pass = 1; auth_key = 1; step();
    chk("R11 mac beats auth", mode, 0);
    do_auth(2, 1);
    sess_rst = 1; mac_valid = 1; mac_ok = 1; auth_valid = 1; auth_pass = 1; pw_valid = 1; pw_pass = 1; step();
    chk("R11 rst beats auth", mode, 0);
    chk("R11 rst discards pw", pw_active, 0);
    do_auth(0, 1);
    auth_valid = 1; auth_pass = 0; auth_key = 0; enc_req = 1; step();
    chk("R11 auth fail beats enc", mode, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      sess_rst   = ($urandom_range(0, 40) == 0);
      pw_valid   = ($urandom_range(0, 3) == 0);
      pw_pass    = ($urandom_range(0, 3) != 0);
      pw_write   = $urandom_range(0, 1);
      pw_set     = 3'($urandom_range(0, 7));
      pw_limit   = 3'($urandom_range(3, 7));
      auth_valid = ($urandom_range(0, 5) == 0);
      auth_pass  = ($urandom_range(0, 3) != 0);
      auth_key   = 2'($urandom_range(0, 3));
      auth_limit = 3'($urandom_range(3, 7));
      enc_req    = ($urandom_range(0, 3) == 0);
      mac_valid  = ($urandom_range(0, 3) == 0);
      mac_ok     = ($urandom_range(0, 7) != 0);
      zpw_en     = $urandom_range(0, 1);
      zpw_set    = 3'($urandom_range(0, 7));
      zkey_en    = $urandom_range(0, 1);
      zkey       = 2'($urandom_range(0, 3));
      zenc       = $urandom_range(0, 1);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule